// File: doc/BRIEF.md
# Comma Detector and Byte Aligner

This block sits behind a free-running deserializer that delivers received serial bits as 10-bit words with no knowledge of where code groups begin. It joins each new word with the one before it into a 20-bit window. It then tests all ten bit offsets of that window for the negative-disparity K28.5 comma. When it finds one, it records that offset and re-cuts every following output word on it, so that code groups land on 10-bit boundaries. A one-word sync pulse marks the output word that carries the comma.

Alignment runs only while the enable input is high. While it is low, the block passes the deserializer words through unchanged, raises no sync pulse and forgets the stored offset. The latency from input to output is the same in every mode. Downstream decoding and link-state logic never see a change in timing when a realignment happens.

Top module: `comma_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, `data_out` becomes 0 and `sync_out` becomes 0, and the stored offset returns to 0.
- R2: Bit 0 of every word is the earliest received bit. The comma searched for is 0011111010 in arrival order, which is the word value 10'h17C with this bit order. Its complement, 10'h283 (the positive-disparity form), is not a trigger.
- R3: With `align_en` high, a comma that starts at any of the 10 bit offsets of a word is found. The output word for that word then equals 10'h17C.
- R4: `sync_out` is high for exactly the output word that carries a detected comma and is low for every other word.
- R5: After alignment, every following output word is cut at the stored offset. A later comma at the same offset leaves that offset unchanged. A comma at a different offset moves it.
- R6: With `align_en` low, `data_out` repeats the input words unframed, `sync_out` stays low even when a comma is present, and the stored offset is cleared to 0.
- R7: A positive-disparity comma (10'h283) arriving while alignment is enabled causes no sync pulse and does not change the stored offset.
- R8: Input word k, counting from the first edge after reset, reaches `data_out` after clock edge k+2. The latency is the same in passthrough mode, in aligned mode and in the word where realignment occurs. The `align_en` value that applies to output word k is the one sampled together with input word k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| align_en | input | 1 | Enables comma search and alignment |
| in_word | input | 10 | Unframed word from the deserializer, bit 0 first received |
| data_out | output | 10 | Aligned (or passthrough) word, registered |
| sync_out | output | 1 | One-word pulse marking a comma-carrying output word |

## Verification
Every output word is due exactly two edges after its input word was sampled. The bench therefore drives word k on the falling edge before edge k and compares output word k-3 on that same falling edge. The offset held in the reference model advances in the same order as the words, so a realignment shows up in the very word where the comma appears. The `align_en` value that governs a word is taken from the next word's sample, matching the one-word look-ahead of the window.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int unsigned WORD_W = 10;
  // R2: negative-disparity K28.5, bit 0 = first received bit
  localparam logic [WORD_W-1:0] COMMA_NEG = 10'h17C;
endpackage

// File: rtl/ca_window.sv
module ca_window #(
  parameter int unsigned W = ca_pkg::WORD_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   in_word,
  input  logic           align_en,
  output logic [2*W-1:0] window,
  output logic           en_q
);
  logic [W-1:0] cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
      en_q   <= 1'b0;
    end else begin
      cur_q  <= in_word;
      prev_q <= cur_q;
      en_q   <= align_en;
    end
  end

  // older word occupies the low half: earlier bits sit at lower indices
  assign window = {cur_q, prev_q};

  a_r8_shift_chain: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> window[W-1:0] == $past(window[2*W-1:W]));
endmodule

// File: rtl/ca_comma_search.sv
module ca_comma_search #(
  parameter int unsigned   W     = ca_pkg::WORD_W,
  parameter logic [W-1:0]  COMMA = ca_pkg::COMMA_NEG,
  localparam int unsigned  OFF_W = $clog2(W)
) (
  input  logic [2*W-1:0]  window,
  output logic            hit,
  output logic [OFF_W-1:0] hit_off
);
  logic [W-1:0] match;

  for (genvar g = 0; g < W; g++) begin : g_off
    assign match[g] = (window[g +: W] == COMMA);
  end

  always_comb begin
    hit     = |match;
    hit_off = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (match[i]) hit_off = OFF_W'(i);
    end
  end
endmodule

// File: rtl/ca_offset_ctrl.sv
module ca_offset_ctrl #(
  parameter int unsigned  W     = ca_pkg::WORD_W,
  localparam int unsigned OFF_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic             hit,
  input  logic [OFF_W-1:0] hit_off,
  output logic [OFF_W-1:0] sel_off,
  output logic             mark
);
  logic [OFF_W-1:0] off_q;

  always_comb begin
    if (!en_q)    sel_off = '0;
    else if (hit) sel_off = hit_off;
    else          sel_off = off_q;
  end

  assign mark = en_q & hit;

  always_ff @(posedge clk) begin
    if (rst) off_q <= '0;
    else     off_q <= sel_off;
  end

  // R6: disabled alignment forgets the offset
  a_r6_off_cleared: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> off_q == '0);
  // R5: offset held when no comma is seen
  a_r5_off_stable: assert property (@(posedge clk) disable iff (rst)
    (en_q && !hit) |=> $stable(off_q));
endmodule

// File: rtl/ca_out_stage.sv
module ca_out_stage #(
  parameter int unsigned  W     = ca_pkg::WORD_W,
  parameter logic [W-1:0] COMMA = ca_pkg::COMMA_NEG,
  localparam int unsigned OFF_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2*W-1:0]   window,
  input  logic [OFF_W-1:0] sel_off,
  input  logic             mark,
  output logic [W-1:0]     data_out,
  output logic             sync_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      sync_out <= 1'b0;
    end else begin
      data_out <= window[sel_off +: W];
      sync_out <= mark;
    end
  end

  // R4 / R3: a pulse always accompanies the comma itself
  a_r4_sync_on_comma: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> data_out == COMMA);
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int unsigned  W     = ca_pkg::WORD_W,
  parameter logic [W-1:0] COMMA = ca_pkg::COMMA_NEG,
  localparam int unsigned OFF_W = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         align_en,
  input  logic [W-1:0] in_word,
  output logic [W-1:0] data_out,
  output logic         sync_out
);
  logic [2*W-1:0]   window;
  logic             en_q, hit, mark;
  logic [OFF_W-1:0] hit_off, sel_off;

  ca_window #(.W(W)) u_win (
    .clk(clk), .rst(rst), .in_word(in_word), .align_en(align_en),
    .window(window), .en_q(en_q));

  ca_comma_search #(.W(W), .COMMA(COMMA)) u_srch (
    .window(window), .hit(hit), .hit_off(hit_off));

  ca_offset_ctrl #(.W(W)) u_ctl (
    .clk(clk), .rst(rst), .en_q(en_q), .hit(hit), .hit_off(hit_off),
    .sel_off(sel_off), .mark(mark));

  ca_out_stage #(.W(W), .COMMA(COMMA)) u_out (
    .clk(clk), .rst(rst), .window(window), .sel_off(sel_off), .mark(mark),
    .data_out(data_out), .sync_out(sync_out));

  // R6: no pulse while alignment is off
  a_r6_no_sync_off: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !sync_out);
endmodule

// File: tb/comma_aligner_tb_top.sv
`timescale 1ns/1ps
module comma_aligner_tb_top;
  localparam int N  = 400;
  localparam int NB = (N + 4) * 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic align_en = 1'b1;
  logic [9:0] in_word = '0;
  logic [9:0] data_out;
  logic sync_out;

  always #2.5 clk = ~clk;

  comma_aligner dut_i (
    .clk(clk), .rst(rst), .align_en(align_en), .in_word(in_word),
    .data_out(data_out), .sync_out(sync_out));

  bit stream [NB];
  bit neg_start [NB];
  bit en_arr [N + 4];
  int checks = 0, fails = 0;
  int held = 0;
  bit done = 0;

  function automatic logic [9:0] word_at(int w);
    logic [9:0] v;
    for (int i = 0; i < 10; i++) v[i] = stream[10*w + i];
    return v;
  endfunction

  function automatic logic [9:0] bits_from(int b);
    logic [9:0] v;
    for (int i = 0; i < 10; i++) v[i] = stream[b + i];
    return v;
  endfunction

  task automatic put_comma(int pos, bit neg);
    logic [9:0] c = neg ? 10'h17C : 10'h283;  // R2 / R7 patterns
    for (int i = 0; i < 10; i++) stream[pos + i] = c[i];
    if (neg) neg_start[pos] = 1'b1;
  endtask

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_word(int j);
    bit en = en_arr[j + 1];
    int found = -1;
    logic [9:0] exp;
    bit es = 1'b0;
    string tag;
    if (!en) begin
      held = 0;
      exp  = word_at(j);
      tag  = "R6 passthrough";
    end else begin
      for (int o = 0; o < 10; o++) if (neg_start[10*j + o]) found = o;
      if (found >= 0) begin held = found; es = 1'b1; end
      exp = bits_from(10*j + held);
      if (es) tag = "R3 R8 comma word";
      else if (j >= 330 && j < 340) tag = "R7 positive comma ignored";
      else tag = "R5 held offset";
    end
    check(tag, data_out, exp);
    check(es ? "R4 sync pulse" : (en ? "R4 no sync" : "R6 no sync"),
          {9'd0, sync_out}, {9'd0, es});
    if (es) check("R2 comma value", data_out, 10'h17C);
  endtask

  initial begin
    // filler: period-7 pattern 0101010, no run of two ones
    for (int b = 0; b < NB; b++) begin
      stream[b] = ((b % 7) == 1 || (b % 7) == 3 || (b % 7) == 5);
      neg_start[b] = 1'b0;
    end
    for (int o = 0; o < 10; o++) put_comma(10*(20 + 30*o) + o, 1'b1);
    put_comma(10*305 + 9, 1'b1);   // R5 same offset again
    put_comma(10*330 + 5, 1'b0);   // R7 positive-disparity form
    put_comma(10*350 + 3, 1'b1);   // R6 comma while disabled
    put_comma(10*380 + 7, 1'b1);
    for (int b = 10*N; b < NB; b++) stream[b] = 1'b0;
    for (int w = 0; w < N + 4; w++) en_arr[w] = !(w >= 340 && w <= 370);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset data", data_out, 10'h000);
    check("R1 reset sync", {9'd0, sync_out}, 10'h000);

    for (int cyc = 0; cyc < N + 3; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (cyc >= 3) check_word(cyc - 3);
      rst      = 1'b0;
      in_word  = (cyc < N) ? word_at(cyc) : 10'h000;
      align_en = en_arr[cyc];
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule